// File: doc/BRIEF.md
# Shared Bus Request Selector

This block lets four on-chip bus masters share one external request/grant pair on a PCI-style shared bus. Each master has its own active-low request and grant. The block merges the requests into one external request. The external arbiter answers on the single external grant, and the block hands that grant on to exactly one internal master. When several masters are waiting, a round-robin pointer settles which one gets it. The indices are fixed: 0 and 1 are the two DMA channels, 2 is the address translation unit and 3 is the bridge port.

A master keeps the bus from the moment it is chosen until it drops its request or the external grant goes away. When the external grant stays asserted while no internal master is asking, the bus is parked on this chip. The block then reports which master owns the parked bus. It also raises the enable for the low 32-bit address/data, byte-enable and parity lanes, so the bus does not float. The enable for the upper 64-bit extension lanes is raised only during real ownership and never while parked.

All request and grant signals are sampled on the rising clock edge. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `bus_req_selector`

## Requirements
- R1: While reset is applied and after it is released with no stimulus, every `int_gnt_n` bit is 1, `ext_req_n` is 1, `park_valid` is 0, `park_idx` is 0, and both lane enables are 0.
- R2: `ext_req_n` is 0 in the cycle after a rising edge at which at least one `int_req_n` bit was 0, and 1 in the cycle after an edge at which all were 1.
- R3: At most one bit of `int_gnt_n` is 0 at any time.
- R4: If no master owns the bus, `ext_gnt_n` is 0 and at least one request is pending at a rising edge, then after that edge `int_gnt_n[i]` is 0 for the selected master i.
- R5: Selection searches the master indices in ascending order with wrap-around. The search starts one past the index granted last, and at index 0 after reset. Bit i of `int_req_n`/`int_gnt_n` belongs to master i.
- R6: An owning master keeps its grant, and it does not move, while its own request and `ext_gnt_n` stay 0, whatever the other masters request.
- R7: Ownership ends after the first edge at which the owner's request is 1 or `ext_gnt_n` is 1. No new master is chosen at that same edge.
- R8: No internal grant is given at an edge where `ext_gnt_n` is 1.
- R9: `park_valid` is 1 in the cycle after an edge with `ext_gnt_n` 0, no request pending and at least one grant since reset. `park_idx` always shows the index of the master granted last.
- R10: `lane_lo_en` is 1 whenever a master owns the bus or `park_valid` is 1. `lane_hi_en` is 1 only while a master owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req_n | input | 4 | Active-low requests, bit i from master i |
| int_gnt_n | output | 4 | Active-low grants, bit i to master i |
| ext_req_n | output | 1 | Active-low merged external request |
| ext_gnt_n | input | 1 | Active-low grant from the external arbiter |
| park_valid | output | 1 | Bus is parked on this chip |
| park_idx | output | 2 | Index of the master granted last |
| lane_lo_en | output | 1 | Drive enable for low address/data, byte-enable and parity lanes |
| lane_hi_en | output | 1 | Drive enable for upper 64-bit extension lanes |

## Verification
Two situations can fall on the same clock edge. In the first, the owner releases the bus while other masters are still requesting, so the release and the next round-robin choice compete; the block must leave a gap cycle and then pick from the moved pointer. In the second, the last request drops while the external grant is held, so parking starts; if a request comes back at that edge instead, parking must not start. The bench provokes both with directed sequences. It also runs an exhaustive sweep of every request pattern and a long pseudo-random run of request and grant combinations. A bench-side model built from the requirements predicts every output in every cycle.

// File: rtl/bus_sel_pkg.sv
package bus_sel_pkg;

  // Advance a master index by one, wrapping at the master count.
  function automatic int unsigned wrap_next(input int unsigned idx,
                                            input int unsigned count);
    if (idx + 1 >= count) return 0;
    return idx + 1;
  endfunction

endpackage

// File: rtl/rsel_rst_sync.sv
module rsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/rsel_rr_pick.sv
module rsel_rr_pick #(
  parameter int N_MASTERS = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] req_act,
  input  logic [IW-1:0]        ptr,
  output logic                 pick_valid,
  output logic [IW-1:0]        pick_idx
);

  // The loop walks from the farthest offset down to offset zero, so the
  // candidate closest to the pointer writes last and wins.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int k = N_MASTERS - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N_MASTERS) j = j - N_MASTERS;
      if (req_act[j]) begin
        pick_valid = 1'b1;
        pick_idx   = IW'(j);
      end
    end
  end

endmodule

// File: rtl/rsel_owner.sv
module rsel_owner
  import bus_sel_pkg::*;
#(
  parameter int N_MASTERS = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_act,
  input  logic                 ext_gnt_act,
  input  logic                 pick_valid,
  input  logic [IW-1:0]        pick_idx,
  output logic                 owner_valid,
  output logic [IW-1:0]        owner_idx,
  output logic [IW-1:0]        ptr,
  output logic                 last_valid,
  output logic [IW-1:0]        last_idx
);

  logic          own_v_d, last_v_d;
  logic [IW-1:0] own_i_d, ptr_d, last_i_d;
  logic          own_en, ptr_en, take_new, release_now;

  assign release_now = owner_valid && (!req_act[owner_idx] || !ext_gnt_act);
  assign take_new    = !owner_valid && ext_gnt_act && pick_valid;

  always_comb begin
    own_v_d  = owner_valid;
    own_i_d  = owner_idx;
    ptr_d    = ptr;
    last_v_d = last_valid;
    last_i_d = last_idx;
    own_en   = release_now || take_new;
    ptr_en   = take_new;
    if (release_now) begin
      own_v_d = 1'b0;
    end else if (take_new) begin
      own_v_d  = 1'b1;
      own_i_d  = pick_idx;
      ptr_d    = IW'(wrap_next(int'(pick_idx), N_MASTERS));
      last_v_d = 1'b1;
      last_i_d = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_valid <= 1'b0;
      owner_idx   <= '0;
      last_valid  <= 1'b0;
      last_idx    <= '0;
    end else if (own_en) begin
      owner_valid <= own_v_d;
      owner_idx   <= own_i_d;
      last_valid  <= last_v_d;
      last_idx    <= last_i_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end

  assert_hold_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && req_act[owner_idx] && ext_gnt_act)
      |=> (owner_valid && $stable(owner_idx)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && !ext_gnt_act) |=> !owner_valid);

  assert_no_grant_without_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_valid && !ext_gnt_act) |=> !owner_valid);

endmodule

// File: rtl/rsel_park.sv
module rsel_park (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic ext_gnt_act,
  input  logic last_valid,
  input  logic owner_valid,
  output logic park_valid,
  output logic lane_lo_en,
  output logic lane_hi_en
);

  logic park_d;

  always_comb begin
    park_d = last_valid && ext_gnt_act && !any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) park_valid <= 1'b0;
    else        park_valid <= park_d;
  end

  assign lane_lo_en = owner_valid || park_valid;
  assign lane_hi_en = owner_valid;

  assert_park_not_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    park_valid |-> !owner_valid);

  assert_hi_lane_off_when_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    park_valid |-> !lane_hi_en);

endmodule

// File: rtl/bus_req_selector.sv
module bus_req_selector #(
  parameter int N_MASTERS = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] int_req_n,
  output logic [N_MASTERS-1:0] int_gnt_n,
  output logic                 ext_req_n,
  input  logic                 ext_gnt_n,
  output logic                 park_valid,
  output logic [IW-1:0]        park_idx,
  output logic                 lane_lo_en,
  output logic                 lane_hi_en
);

  logic                 rst_s_n;
  logic [N_MASTERS-1:0] req_act;
  logic                 any_req, ext_gnt_act;
  logic                 pick_valid;
  logic [IW-1:0]        pick_idx, ptr;
  logic                 owner_valid, last_valid;
  logic [IW-1:0]        owner_idx, last_idx;
  logic                 ext_req_q;

  rsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_in_n(rst_n), .rst_out_n(rst_s_n)
  );

  assign req_act     = ~int_req_n;
  assign any_req     = |req_act;
  assign ext_gnt_act = !ext_gnt_n;

  rsel_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req_act(req_act), .ptr(ptr),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  rsel_owner #(.N_MASTERS(N_MASTERS)) u_owner (
    .clk(clk), .rst_n(rst_s_n),
    .req_act(req_act), .ext_gnt_act(ext_gnt_act),
    .pick_valid(pick_valid), .pick_idx(pick_idx),
    .owner_valid(owner_valid), .owner_idx(owner_idx), .ptr(ptr),
    .last_valid(last_valid), .last_idx(last_idx)
  );

  rsel_park u_park (
    .clk(clk), .rst_n(rst_s_n),
    .any_req(any_req), .ext_gnt_act(ext_gnt_act),
    .last_valid(last_valid), .owner_valid(owner_valid),
    .park_valid(park_valid), .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en)
  );

  // Merged request, registered so the external pin comes straight off a flop.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ext_req_q <= 1'b0;
    else          ext_req_q <= any_req;
  end
  assign ext_req_n = !ext_req_q;

  generate
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
      assign int_gnt_n[g] = !(owner_valid && (owner_idx == IW'(g)));
    end
  endgenerate

  assign park_idx = last_idx;

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(~int_gnt_n));

  assert_ext_req_follows_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|(~int_req_n)) |=> !ext_req_n);

  assert_grant_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!owner_valid && !(|(~int_req_n))) |=> (&int_gnt_n));

endmodule

// File: tb/test_bus_req_selector.sv
`timescale 1ns/1ps
module test_bus_req_selector;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] int_req_n;
  logic [3:0] int_gnt_n;
  logic       ext_req_n;
  logic       ext_gnt_n;
  logic       park_valid;
  logic [1:0] park_idx;
  logic       lane_lo_en, lane_hi_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Requirement-derived reference state
  bit      m_own_v, m_last_v, m_park, m_ext_act;
  int      m_own, m_ptr, m_last;

  always #10 clk = ~clk;   // 50 MHz

  bus_req_selector i_bus_req_selector (
    .clk(clk), .rst_n(rst_n), .int_req_n(int_req_n), .int_gnt_n(int_gnt_n),
    .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n), .park_valid(park_valid),
    .park_idx(park_idx), .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [3:0] eg;
    eg = m_own_v ? ~(4'b0001 << m_own) : 4'b1111;
    check(int_gnt_n == eg, {tag, " R4/R5/R6/R7 grant vector"}, int_gnt_n, eg);
    check(ext_req_n == !m_ext_act, {tag, " R2 ext_req_n"}, ext_req_n, !m_ext_act);
    check(park_valid == m_park, {tag, " R9 park_valid"}, park_valid, m_park);
    check(park_idx == 2'(m_last), {tag, " R9 park_idx"}, park_idx, m_last);
    check(lane_lo_en == (m_own_v || m_park), {tag, " R10 lane_lo_en"}, lane_lo_en, m_own_v || m_park);
    check(lane_hi_en == m_own_v, {tag, " R10 lane_hi_en"}, lane_hi_en, m_own_v);
    check($countones(~int_gnt_n) <= 1, {tag, " R3 single grant"}, int_gnt_n, 0);
  endtask

  task automatic step(input logic [3:0] r, input logic g, input string tag);
    logic [3:0] act;
    bit any, ga, np;
    @(negedge clk);
    int_req_n = r;
    ext_gnt_n = g;
    @(posedge clk);
    act = ~r; any = |act; ga = !g;
    np = m_last_v && ga && !any;
    m_ext_act = any;
    if (m_own_v) begin
      if (!act[m_own] || !ga) m_own_v = 0;
    end else if (ga && any) begin
      int pick = -1;
      for (int k = 3; k >= 0; k--) begin
        int j = (m_ptr + k) % 4;
        if (act[j]) pick = j;
      end
      m_own_v = 1; m_own = pick; m_ptr = (pick + 1) % 4;
      m_last_v = 1; m_last = pick;
    end
    m_park = np;
    #5;
    compare_all(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; int_req_n = 4'hF; ext_gnt_n = 1'b1;
    m_own_v = 0; m_last_v = 0; m_park = 0; m_ext_act = 0;
    m_own = 0; m_ptr = 0; m_last = 0;
    repeat (3) @(posedge clk);
    #5;
    check(int_gnt_n == 4'hF && ext_req_n && !park_valid && park_idx == 0
          && !lane_lo_en && !lane_hi_en, "R1 outputs during reset", int_gnt_n, 4'hF);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(4'hF, 1'b1, "R1 idle after reset");
    check(int_gnt_n == 4'hF && ext_req_n, "R1 idle state", int_gnt_n, 4'hF);

    // Request with grant withheld: request goes out, nobody is granted (R2, R8)
    step(4'b1011, 1'b1, "R8 grant withheld");
    check(ext_req_n == 1'b0, "R2 request raised", ext_req_n, 0);
    check(int_gnt_n == 4'hF, "R8 no grant without external grant", int_gnt_n, 4'hF);
    step(4'b1011, 1'b0, "R4 first grant");
    check(int_gnt_n == 4'b1011, "R4 master 2 granted", int_gnt_n, 4'b1011);
    step(4'b1010, 1'b0, "R6 others wait");
    check(int_gnt_n == 4'b1011, "R6 owner held", int_gnt_n, 4'b1011);
    // Owner drops while master 0 waits: gap cycle, then pointer from 3 wraps to 0
    step(4'b1110, 1'b0, "R7 release");
    check(int_gnt_n == 4'hF, "R7 gap cycle after release", int_gnt_n, 4'hF);
    step(4'b1110, 1'b0, "R5 wrap");
    check(int_gnt_n == 4'b1110, "R5 master 0 after wrap", int_gnt_n, 4'b1110);
    step(4'b0000, 1'b0, "R6 all request");
    check(int_gnt_n == 4'b1110, "R6 owner 0 kept", int_gnt_n, 4'b1110);
    step(4'b0001, 1'b0, "R7 release with waiters");
    step(4'b0001, 1'b0, "R5 next after 0");
    check(int_gnt_n == 4'b1101, "R5 master 1 follows 0", int_gnt_n, 4'b1101);
    // External grant removed mid-ownership
    step(4'b0001, 1'b1, "R7 ext grant lost");
    check(int_gnt_n == 4'hF, "R7 ext grant removal releases", int_gnt_n, 4'hF);
    // Parking: grant held with no requests
    step(4'hF, 1'b0, "R9 idle under grant");
    check(park_valid && park_idx == 2'd1, "R9 parked on master 1", {park_valid, park_idx}, 3'b101);
    check(lane_lo_en && !lane_hi_en, "R10 low lanes only while parked", {lane_lo_en, lane_hi_en}, 2'b10);
    // Request returns on the edge where parking would continue
    step(4'b0111, 1'b0, "R9 park ends on request");
    check(!park_valid, "R9 parking ended by new request", park_valid, 0);
    step(4'b0111, 1'b0, "R5 master 3 from ptr 2");
    check(int_gnt_n == 4'b0111 && lane_hi_en, "R5 master 3 granted", int_gnt_n, 4'b0111);
    step(4'hF, 1'b1, "drain");

    // Exhaustive: every request pattern under a held grant, then drain
    for (int p = 0; p < 16; p++) begin
      step(4'(p), 1'b0, "sweep grant");
      step(4'(p), 1'b0, "sweep hold");
      step(4'hF, 1'b0, "sweep park");
      step(4'hF, 1'b1, "sweep idle");
    end

    // Long pseudo-random run
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] | {4{lfsr[9] & lfsr[8]}}, lfsr[6] & lfsr[5], "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule